// File: doc/BRIEF.md
# Bayer Per-Channel Digital Gain

This block scales a stream of 8-bit raw mosaic pixels coming off an image sensor. Every pixel arrives with a valid strobe and with the parity of its row and column. From those two bits the block works out which colour site the pixel sits on (red, blue, or one of the two greens) and picks the matching 11-bit unsigned gain coefficient.

Each pixel is processed in a fixed order. First an optional dark level is removed. Then the pixel is multiplied by the site coefficient. The binary point of the coefficient is set by a format field, and the fraction bits are dropped. Next a global power-of-two boost is applied, and the result is clamped to 8 bits. A small register-write port loads the four coefficients, a control word and the dark level. The block sits in the pixel path between the sensor readout and downstream colour processing. It adds a constant two-cycle latency.

Register map, addressed by `cfg_addr`:
- 0: coefficient for the green site on red rows.
- 1: coefficient for red.
- 2: coefficient for blue.
- 3: coefficient for the green site on blue rows.
- 4: control word. Bits [4:0] are the format, [7:5] the boost code, [8] the mirror flag and [9] the automatic-dark flag.
- 5: dark level in bits [7:0].

Top module: `bgain_top`

## Requirements
- R1: The site is decoded from (`row_odd`, effective column parity). (0,0) is red and uses register 1. (0,1) is green-on-red-row and uses register 0. (1,0) is green-on-blue-row and uses register 3. (1,1) is blue and uses register 2.
- R2: The four coefficients are 11 bits wide and written from `cfg_wdata[10:0]`. Each comes out of reset as 256, so a reset block passes pixels unchanged.
- R3: A format value f of 0, 1, 2 or 3 reads the coefficients as unsigned 3.8, 4.7, 5.6 or 6.5. The product is shifted right by 8−f, and the dropped fraction bits are truncated.
- R4: Any format value from 4 to 31 skips the multiply. The dark-corrected pixel goes straight on to the boost stage.
- R5: A boost code n from 0 to 6 shifts the scaled value left by n (×1 to ×64). Code 7 acts as ×64.
- R6: When control bit 9 is 0, the dark level is subtracted from every pixel and the result floors at 0. When bit 9 is 1, which is the reset value, no dark level is subtracted. The dark level resets to 0.
- R7: A result above 255 is output as 255.
- R8: `vld_out` equals `pix_valid` from two clock edges earlier. A pixel's result appears two edges after the pixel is sampled.
- R9: `pix_out` is 0 whenever `vld_out` is low, including right after reset.
- R10: When control bit 8 (mirror) is 1, the column parity used for site selection is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 16 | Register write data |
| pix_valid | input | 1 | Input pixel strobe |
| pix_data | input | 8 | Raw input pixel |
| row_odd | input | 1 | Row parity of the pixel |
| col_odd | input | 1 | Column parity of the pixel |
| vld_out | output | 1 | Output pixel strobe |
| pix_out | output | 8 | Gained, saturated pixel |

## Verification
The hardest case to reach is a pixel whose dark-corrected value, site coefficient, format and boost all combine to land exactly at the saturation edge or the truncation edge. The stimulus for these cases is built from chosen values. One case is a coefficient of 257 with a pixel of 200, which has a fractional product that must truncate. Another is a ×3 site coefficient that pushes 100 past 255. A third is boost code 7 applied to a bypassed pixel of 3. Mirroring is exercised by sending the same parity pair before and after the flag is set. The flag must move the pixel to a different coefficient.

// File: rtl/bgain_pkg.sv
package bgain_pkg;
    parameter int PIX_W   = 8;
    parameter int COEF_W  = 11;
    parameter int FMT_W   = 5;
    parameter int BOOST_W = 3;
    parameter int ADDR_W  = 3;
    parameter int DATA_W  = 16;

    localparam int NUM_CH    = 4;
    localparam int NUM_FMT   = 4;
    localparam int FRAC_BASE = COEF_W - 3;
    localparam int BOOST_MAX = 6;
    localparam int PROD_W    = PIX_W + COEF_W;
    localparam int SHL_W     = PROD_W + BOOST_MAX;

    localparam logic [COEF_W-1:0] COEF_ONE = COEF_W'(1) << FRAC_BASE;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] ADDR_DARK = ADDR_W'(5);

    typedef enum logic [1:0] {
        CH_GR = 2'd0,
        CH_R  = 2'd1,
        CH_B  = 2'd2,
        CH_GB = 2'd3
    } chan_e;

    typedef struct packed {
        logic             auto_dark;
        logic             mirror;
        logic [BOOST_W-1:0] boost;
        logic [FMT_W-1:0] fmt;
    } ctrl_t;

    function automatic chan_e site_chan(input logic ro, input logic co);
        unique case ({ro, co})
            2'b00:   return CH_R;
            2'b01:   return CH_GR;
            2'b10:   return CH_GB;
            default: return CH_B;
        endcase
    endfunction
endpackage

// File: rtl/bgain_cfg_regs.sv
module bgain_cfg_regs
    import bgain_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [ADDR_W-1:0]              cfg_addr,
    input  logic [DATA_W-1:0]              cfg_wdata,
    output logic [NUM_CH-1:0][COEF_W-1:0]  coef,
    output ctrl_t                          ctrl,
    output logic [PIX_W-1:0]               dark_lvl
);
    localparam int CTRL_W = $bits(ctrl_t);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_coef
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                coef[g] <= COEF_ONE;
            else if (cfg_we && cfg_addr == ADDR_W'(g))
                coef[g] <= cfg_wdata[COEF_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl           <= '0;
            ctrl.auto_dark <= 1'b1;
            dark_lvl       <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_CTRL)
                ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            if (cfg_addr == ADDR_DARK)
                dark_lvl <= cfg_wdata[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/bgain_front.sv
module bgain_front
    import bgain_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pix_valid,
    input  logic [PIX_W-1:0]              pix_data,
    input  logic                          row_odd,
    input  logic                          col_odd,
    input  logic [NUM_CH-1:0][COEF_W-1:0] coef,
    input  ctrl_t                         ctrl,
    input  logic [PIX_W-1:0]              dark_lvl,
    output logic                          s1_valid,
    output logic [PIX_W-1:0]              s1_val,
    output logic [COEF_W-1:0]             s1_coef,
    output logic [FMT_W-1:0]              s1_fmt,
    output logic [BOOST_W-1:0]            s1_shl
);
    logic [PIX_W-1:0]   dark_eff;
    logic [PIX_W-1:0]   corrected;
    chan_e              site;
    logic [BOOST_W-1:0] shl_clamped;

    always_comb begin
        dark_eff    = ctrl.auto_dark ? '0 : dark_lvl;
        corrected   = (pix_data > dark_eff) ? pix_data - dark_eff : '0;
        site        = site_chan(row_odd, col_odd ^ ctrl.mirror);
        shl_clamped = (ctrl.boost > BOOST_W'(BOOST_MAX)) ? BOOST_W'(BOOST_MAX) : ctrl.boost;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_val   <= '0;
            s1_coef  <= '0;
            s1_fmt   <= '0;
            s1_shl   <= '0;
        end else begin
            s1_valid <= pix_valid;
            if (pix_valid) begin
                s1_val  <= corrected;
                s1_coef <= coef[site];
                s1_fmt  <= ctrl.fmt;
                s1_shl  <= shl_clamped;
            end
        end
    end
endmodule

// File: rtl/bgain_back.sv
module bgain_back
    import bgain_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s1_valid,
    input  logic [PIX_W-1:0]   s1_val,
    input  logic [COEF_W-1:0]  s1_coef,
    input  logic [FMT_W-1:0]   s1_fmt,
    input  logic [BOOST_W-1:0] s1_shl,
    output logic               vld_out,
    output logic [PIX_W-1:0]   pix_out
);
    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] scaled;
    logic [SHL_W-1:0]  boosted;
    logic [3:0]        frac;
    logic [PIX_W-1:0]  clipped;

    always_comb begin
        product = PROD_W'(s1_val) * PROD_W'(s1_coef);
        frac    = 4'(FRAC_BASE - int'(s1_fmt[1:0]));
        if (s1_fmt < FMT_W'(NUM_FMT))
            scaled = product >> frac;
        else
            scaled = PROD_W'(s1_val);
        boosted = SHL_W'(scaled) << s1_shl;
        clipped = (|boosted[SHL_W-1:PIX_W]) ? '1 : boosted[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_out <= 1'b0;
            pix_out <= '0;
        end else begin
            vld_out <= s1_valid;
            pix_out <= s1_valid ? clipped : '0;
        end
    end
endmodule

// File: rtl/bgain_top.sv
module bgain_top
    import bgain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              row_odd,
    input  logic              col_odd,
    output logic              vld_out,
    output logic [PIX_W-1:0]  pix_out
);
    logic [NUM_CH-1:0][COEF_W-1:0] cfg_coef;
    ctrl_t                         cfg_ctrl;
    logic [PIX_W-1:0]              cfg_dark;
    logic [FMT_W-1:0]              cfg_fmt;
    logic [BOOST_W-1:0]            cfg_boost;
    logic                          cfg_dark_on;

    logic               s1_valid;
    logic [PIX_W-1:0]   s1_val;
    logic [COEF_W-1:0]  s1_coef;
    logic [FMT_W-1:0]   s1_fmt;
    logic [BOOST_W-1:0] s1_shl;

    assign cfg_fmt     = cfg_ctrl.fmt;
    assign cfg_boost   = cfg_ctrl.boost;
    assign cfg_dark_on = !cfg_ctrl.auto_dark;

    bgain_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .coef(cfg_coef), .ctrl(cfg_ctrl), .dark_lvl(cfg_dark)
    );

    bgain_front u_front (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .row_odd(row_odd), .col_odd(col_odd), .coef(cfg_coef), .ctrl(cfg_ctrl),
        .dark_lvl(cfg_dark), .s1_valid(s1_valid), .s1_val(s1_val),
        .s1_coef(s1_coef), .s1_fmt(s1_fmt), .s1_shl(s1_shl)
    );

    bgain_back u_back (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_val(s1_val),
        .s1_coef(s1_coef), .s1_fmt(s1_fmt), .s1_shl(s1_shl),
        .vld_out(vld_out), .pix_out(pix_out)
    );
endmodule

// File: rtl/bgain_top_chk.sv
module bgain_top_chk
    import bgain_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               pix_valid,
    input logic [PIX_W-1:0]   pix_data,
    input logic               vld_out,
    input logic [PIX_W-1:0]   pix_out,
    input logic [FMT_W-1:0]   fmt,
    input logic [BOOST_W-1:0] boost,
    input logic               dark_on,
    input logic [PIX_W-1:0]   dark_lvl
);
    logic [1:0] since_rst;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_rst <= 2'd0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end
    assign warm = (since_rst == 2'd2);

    // R8: strobe delayed by exactly two edges
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (vld_out == $past(pix_valid, 2)));

    // R9: quiet output between pixels
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_out |-> (pix_out == '0));

    // R6: dark level at or above the pixel floors the result
    a_r6_dark_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && vld_out && $past(pix_valid && dark_on && pix_data <= dark_lvl, 2))
        |-> (pix_out == '0));

    // R4: bypass with no boost and no dark returns the raw pixel
    a_r4_bypass_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && vld_out && $past(pix_valid && fmt >= FMT_W'(NUM_FMT) && boost == '0 && !dark_on, 2))
        |-> (pix_out == $past(pix_data, 2)));
endmodule

bind bgain_top bgain_top_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .vld_out(vld_out), .pix_out(pix_out), .fmt(cfg_fmt), .boost(cfg_boost),
    .dark_on(cfg_dark_on), .dark_lvl(cfg_dark)
);

// File: tb/bgain_top_tb.sv
module bgain_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_data = '0;
    logic        row_odd = 1'b0;
    logic        col_odd = 1'b0;
    logic        vld_out;
    logic [7:0]  pix_out;

    int total = 0;
    int bad = 0;

    int sh_coef [4];
    int sh_fmt, sh_boost, sh_mirror, sh_auto, sh_dark;

    always #4 clk = ~clk;

    bgain_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_data(pix_data),
        .row_odd(row_odd), .col_odd(col_odd), .vld_out(vld_out), .pix_out(pix_out)
    );

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int model(input int d, input int ro, input int co);
        int v, c, idx, p, b, r, cm;
        v  = (sh_auto != 0) ? d : ((d > sh_dark) ? d - sh_dark : 0);
        cm = co ^ sh_mirror;
        if (ro == 0) idx = (cm != 0) ? 0 : 1;
        else         idx = (cm != 0) ? 2 : 3;
        c  = sh_coef[idx];
        p  = (sh_fmt < 4) ? ((v * c) >> (8 - sh_fmt)) : v;
        b  = (sh_boost > 6) ? 6 : sh_boost;
        r  = p << b;
        return (r > 255) ? 255 : r;
    endfunction

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 4) sh_coef[addr] = data & 16'h7FF;
        if (addr == 5) sh_dark = data & 8'hFF;
    endtask

    task automatic set_ctrl(input int fmt, input int boost, input int mir, input int autod);
        wr(4, (autod << 9) | (mir << 8) | (boost << 5) | fmt);
        sh_fmt = fmt; sh_boost = boost; sh_mirror = mir; sh_auto = autod;
    endtask

    task automatic push_chk(input string tag, input int d, input int ro, input int co, input int exp);
        @(negedge clk);
        pix_valid = 1'b1; pix_data = 8'(d); row_odd = ro[0]; col_odd = co[0];
        @(negedge clk);
        pix_valid = 1'b0;
        @(negedge clk);
        check({tag, " valid"}, int'(vld_out), 1);
        check(tag, int'(pix_out), exp);
    endtask

    task automatic t_reset();
        check("R9 reset vld_out", int'(vld_out), 0);
        check("R9 reset pix_out", int'(pix_out), 0);
    endtask

    task automatic t_unity();
        for (int s = 0; s < 4; s++)
            push_chk("R2 reset unity gain", 100 + s, s >> 1, s & 1, 100 + s);
    endtask

    task automatic t_sites();
        wr(0, 512); wr(1, 128); wr(2, 384); wr(3, 768);
        push_chk("R1 red site", 100, 0, 0, model(100, 0, 0));
        push_chk("R1 green red-row", 100, 0, 1, model(100, 0, 1));
        push_chk("R1 blue site", 100, 1, 1, model(100, 1, 1));
        push_chk("R1 green blue-row", 80, 1, 0, model(80, 1, 0));
        push_chk("R7 saturate at 255", 100, 1, 0, 255);
    endtask

    task automatic t_mirror();
        set_ctrl(0, 0, 1, 1);
        push_chk("R10 mirror red to Gr", 100, 0, 0, 200);
        push_chk("R10 mirror blue to Gb", 50, 1, 1, 150);
        set_ctrl(0, 0, 0, 1);
    endtask

    task automatic t_formats();
        wr(1, 256);
        set_ctrl(1, 0, 0, 1);
        push_chk("R3 format 4.7", 100, 0, 0, 200);
        set_ctrl(2, 0, 0, 1);
        push_chk("R3 format 5.6", 40, 0, 0, 160);
        set_ctrl(3, 0, 0, 1);
        push_chk("R3 format 6.5", 20, 0, 0, 160);
        set_ctrl(0, 0, 0, 1);
        wr(1, 257);
        push_chk("R3 truncation", 200, 0, 0, 200);
    endtask

    task automatic t_bypass();
        set_ctrl(9, 0, 0, 1);
        push_chk("R4 bypass fmt 9", 173, 0, 0, 173);
        set_ctrl(31, 0, 0, 1);
        push_chk("R4 bypass fmt 31", 77, 1, 0, 77);
    endtask

    task automatic t_boost();
        for (int n = 0; n < 8; n++) begin
            set_ctrl(4, n, 0, 1);
            push_chk("R5 boost code", 3, 0, 1, (n > 6) ? 192 : (3 << n));
        end
        set_ctrl(4, 6, 0, 1);
        push_chk("R7 boost overflow", 5, 0, 1, 255);
    endtask

    task automatic t_dark();
        wr(5, 20);
        set_ctrl(4, 0, 0, 0);
        push_chk("R6 dark subtract", 50, 0, 0, 30);
        push_chk("R6 dark floor", 10, 0, 0, 0);
        set_ctrl(4, 0, 0, 1);
        push_chk("R6 auto dark no subtract", 50, 0, 0, 50);
    endtask

    task automatic t_stream();
        set_ctrl(4, 1, 0, 1);
        @(negedge clk);
        pix_valid = 1'b1; pix_data = 8'd10;
        @(negedge clk);
        pix_data = 8'd60;
        @(negedge clk);
        pix_valid = 1'b0;
        check("R8 first after two edges", int'(pix_out), 20);
        check("R8 first valid", int'(vld_out), 1);
        @(negedge clk);
        check("R8 second next cycle", int'(pix_out), 120);
        @(negedge clk);
        check("R9 idle vld_out", int'(vld_out), 0);
        check("R9 idle pix_out", int'(pix_out), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) sh_coef[i] = 256;
        sh_fmt = 0; sh_boost = 0; sh_mirror = 0; sh_auto = 1; sh_dark = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_unity();
        t_sites();
        t_mirror();
        t_formats();
        t_bypass();
        t_boost();
        t_dark();
        t_stream();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule